// File: doc/BRIEF.md
# Mapped SFR Access Controller

This block sits between an 8-bit microcontroller core and its special function register space. On every register access it decides which of three destinations the address means: the ordinary register area, an alternate register area that reuses a window of the same addresses, or the direction registers of the parallel ports. It raises exactly one registered select strobe for that destination, one clock after the access.

The choice comes from two control bits that the block keeps itself. The first is a sticky map-enable bit in a system control register. It redirects the alternate window while it stays set. The second is a direction-enable bit in a port control register, and it acts as a one-shot. Software sets it with one instruction and reaches a direction register with the next. The block then clears the bit by itself once two machine-cycle phase pulses have gone by. The two control registers always stay in the ordinary area. The block returns their contents on the read data bus and drives zero for every other address.

Top module: `sfr_map_ctrl`

## Requirements
- R1: After a synchronous reset, no select is active, the system control register (address 0xB1) reads 0xA1 and the port control register (address 0xB9) reads 0x00.
- R2: In the cycle after an access (read or write strobe high), exactly one of sel_std, sel_map, sel_dir is high. In the cycle after a cycle with no access, all three are low.
- R3: Bit 4 of 0xB1 is the map-enable bit. It only changes when 0xB1 is written. When it is 1, an access to the window 0xC1 to 0xCB selects the alternate area. When it is 0, such an access selects the ordinary area.
- R4: An access to any address outside the window and outside the port list selects the ordinary area, whatever the map-enable bit holds. This covers 0xC0 and 0xCC.
- R5: Bit 7 of 0xB9 is the direction-enable bit. When it is 1, an access to a port address (0x80, 0x90, 0xA0, 0xB0, 0xE8, 0xF8) selects the direction area. When it is 0, such an access selects the ordinary area.
- R6: The direction-enable bit clears itself on the second phase pulse that follows the write which set it. A pulse in the cycle of that write does not count. The bit never becomes 1 except by a write.
- R7: A write to 0xB9 in the same cycle as the clearing pulse takes priority. The written bit 7 is kept, and writing 1 starts a fresh two-pulse count.
- R8: Accesses to 0xB1 and 0xB9 always select the ordinary area, whatever both control bits hold.
- R9: 0xB1 reads bits 7, 6, 1 and 0 as last written, bit 4 as the map-enable bit, bit 5 as 1 and bits 3 and 2 as 0. 0xB9 reads bit 7 as the direction-enable bit, bit 6 as 0 and bits 5 to 0 as last written.
- R10: sfr_rdata holds the register value in the cycle after a read of 0xB1 or 0xB9, and it is 0x00 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address of the current access |
| sfr_wdata | input | 8 | Write data |
| sfr_rd | input | 1 | Read strobe |
| sfr_wr | input | 1 | Write strobe |
| phase_s2p2 | input | 1 | One-cycle pulse that marks the clearing phase of each machine cycle |
| sfr_rdata | output | 8 | Registered control register read data |
| sel_std | output | 1 | Ordinary area select, registered |
| sel_map | output | 1 | Alternate area select, registered |
| sel_dir | output | 1 | Port direction area select, registered |

## Verification
A wrong map-enable or direction-enable state shows on the very next access to a window or port address, one clock later, as the wrong select strobe. A read of the matching control register exposes the same state on sfr_rdata one clock after the read. An error in the self-clear timer shows as a port access that reaches the direction area one pulse too long or too short. For that reason the bench places port accesses right before and right after each phase pulse, including a pulse that lands in the same cycle as a write.

// File: rtl/sfr_map_pkg.sv
package sfr_map_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    AREA_NONE = 2'd0,
    AREA_STD  = 2'd1,
    AREA_MAP  = 2'd2,
    AREA_DIR  = 2'd3
  } area_e;
endpackage

// File: rtl/sfr_ctrl_regs.sv
module sfr_ctrl_regs
  import sfr_map_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] SYSCON_ADDR = 8'hB1,
  parameter logic [ADDR_W-1:0] DIRCTL_ADDR = 8'hB9,
  parameter int              DIR_LIFE    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rd,
  input  logic              wr,
  input  logic              phase,
  output logic              map_en,
  output logic              dir_en,
  output logic [REG_W-1:0]  rdata
);
  localparam int CNT_W = (DIR_LIFE > 1) ? $clog2(DIR_LIFE) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DIR_LIFE - 1);

  logic [1:0]       sys_hi, sys_lo;
  logic [5:0]       ip_lo;
  logic [CNT_W-1:0] life_cnt;
  logic             wr_sys, wr_dir, rd_sys, rd_dir;
  logic [REG_W-1:0] sys_view, dir_view;

  assign wr_sys = wr && (addr == SYSCON_ADDR);
  assign wr_dir = wr && (addr == DIRCTL_ADDR);
  assign rd_sys = rd && (addr == SYSCON_ADDR);
  assign rd_dir = rd && (addr == DIRCTL_ADDR);

  assign sys_view = {sys_hi, 1'b1, map_en, 2'b00, sys_lo};
  assign dir_view = {dir_en, 1'b0, ip_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_hi   <= 2'b10;
      sys_lo   <= 2'b01;
      map_en   <= 1'b0;
      dir_en   <= 1'b0;
      ip_lo    <= '0;
      life_cnt <= '0;
      rdata    <= '0;
    end else begin
      if (wr_sys) begin
        sys_hi <= wdata[7:6];
        map_en <= wdata[4];
        sys_lo <= wdata[1:0];
      end
      if (wr_dir) begin
        dir_en   <= wdata[7];
        ip_lo    <= wdata[5:0];
        life_cnt <= '0;
      end else if (dir_en && phase) begin
        if (life_cnt == LAST_CNT) begin
          dir_en   <= 1'b0;
          life_cnt <= '0;
        end else begin
          life_cnt <= life_cnt + 1'b1;
        end
      end
      if (rd_sys)      rdata <= sys_view;
      else if (rd_dir) rdata <= dir_view;
      else             rdata <= '0;
    end
  end

  // Independent pulse tally for the self-clear window
  int unsigned chk_pulses;
  always_ff @(posedge clk) begin
    if (rst || wr_dir)        chk_pulses <= 0;
    else if (dir_en && phase) chk_pulses <= chk_pulses + 1;
  end

  AST_DIR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    dir_en |-> chk_pulses < DIR_LIFE);                               // R6
  AST_DIR_NO_SELF_SET: assert property (@(posedge clk) disable iff (rst)
    (!wr_dir && !dir_en) |=> !dir_en);                               // R6
  AST_DIR_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!wr_dir && !phase) |=> $stable(dir_en));                        // R6
  AST_DIR_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> dir_en == $past(wdata[7]));                           // R7
  AST_MAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_sys |=> $stable(map_en));                                    // R3
  AST_SYS_BIT5_ONE: assert property (@(posedge clk) disable iff (rst)
    rd_sys |=> rdata[5]);                                            // R9
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(rd_sys || rd_dir) |=> rdata == '0);                            // R10
endmodule

// File: rtl/sfr_area_decode.sv
module sfr_area_decode
  import sfr_map_pkg::*;
#(
  parameter int                         ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]          SYSCON_ADDR = 8'hB1,
  parameter logic [ADDR_W-1:0]          DIRCTL_ADDR = 8'hB9,
  parameter logic [ADDR_W-1:0]          WIN_LO      = 8'hC1,
  parameter logic [ADDR_W-1:0]          WIN_HI      = 8'hCB,
  parameter int                         NUM_PORTS   = 6,
  parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_ADDRS =
    {8'hF8, 8'hE8, 8'hB0, 8'hA0, 8'h90, 8'h80}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              map_en,
  input  logic              dir_en,
  output logic              sel_std,
  output logic              sel_map,
  output logic              sel_dir
);
  logic [NUM_PORTS-1:0] port_hit;
  logic                 access, is_ctrl, in_win, is_port;
  area_e                area_d;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign port_hit[i] = (addr == PORT_ADDRS[i*ADDR_W +: ADDR_W]);
  end

  assign access  = rd || wr;
  assign is_ctrl = (addr == SYSCON_ADDR) || (addr == DIRCTL_ADDR);
  assign in_win  = (addr >= WIN_LO) && (addr <= WIN_HI);
  assign is_port = |port_hit;

  always_comb begin
    if (!access)                area_d = AREA_NONE;
    else if (is_ctrl)           area_d = AREA_STD;
    else if (is_port && dir_en) area_d = AREA_DIR;
    else if (in_win && map_en)  area_d = AREA_MAP;
    else                        area_d = AREA_STD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_std <= 1'b0;
      sel_map <= 1'b0;
      sel_dir <= 1'b0;
    end else begin
      sel_std <= (area_d == AREA_STD);
      sel_map <= (area_d == AREA_MAP);
      sel_dir <= (area_d == AREA_DIR);
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    access |=> $countones({sel_std, sel_map, sel_dir}) == 1);        // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !access |=> !(sel_std || sel_map || sel_dir));                   // R2
  AST_CTRL_STD: assert property (@(posedge clk) disable iff (rst)
    (access && is_ctrl) |=> sel_std);                                // R8
  AST_OUTSIDE_STD: assert property (@(posedge clk) disable iff (rst)
    (access && !in_win && !is_port) |=> sel_std);                    // R4
  AST_MAP_OFF: assert property (@(posedge clk) disable iff (rst)
    (access && !map_en) |=> !sel_map);                               // R3
  AST_DIR_OFF: assert property (@(posedge clk) disable iff (rst)
    (access && !dir_en) |=> !sel_dir);                               // R5
endmodule

// File: rtl/sfr_map_ctrl.sv
module sfr_map_ctrl
  import sfr_map_pkg::*;
#(
  parameter int                          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]           SYSCON_ADDR = 8'hB1,
  parameter logic [ADDR_W-1:0]           DIRCTL_ADDR = 8'hB9,
  parameter logic [ADDR_W-1:0]           WIN_LO      = 8'hC1,
  parameter logic [ADDR_W-1:0]           WIN_HI      = 8'hCB,
  parameter int                          NUM_PORTS   = 6,
  parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_ADDRS  =
    {8'hF8, 8'hE8, 8'hB0, 8'hA0, 8'h90, 8'h80},
  parameter int                          DIR_LIFE    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [7:0]        sfr_wdata,
  input  logic              sfr_rd,
  input  logic              sfr_wr,
  input  logic              phase_s2p2,
  output logic [7:0]        sfr_rdata,
  output logic              sel_std,
  output logic              sel_map,
  output logic              sel_dir
);
  logic map_en, dir_en;

  sfr_ctrl_regs #(
    .ADDR_W(ADDR_W), .SYSCON_ADDR(SYSCON_ADDR),
    .DIRCTL_ADDR(DIRCTL_ADDR), .DIR_LIFE(DIR_LIFE)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(sfr_addr), .wdata(sfr_wdata),
    .rd(sfr_rd), .wr(sfr_wr), .phase(phase_s2p2),
    .map_en(map_en), .dir_en(dir_en), .rdata(sfr_rdata)
  );

  sfr_area_decode #(
    .ADDR_W(ADDR_W), .SYSCON_ADDR(SYSCON_ADDR), .DIRCTL_ADDR(DIRCTL_ADDR),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .NUM_PORTS(NUM_PORTS),
    .PORT_ADDRS(PORT_ADDRS)
  ) u_dec (
    .clk(clk), .rst(rst), .addr(sfr_addr), .rd(sfr_rd), .wr(sfr_wr),
    .map_en(map_en), .dir_en(dir_en),
    .sel_std(sel_std), .sel_map(sel_map), .sel_dir(sel_dir)
  );
endmodule

// File: tb/sfr_map_ctrl_tb.sv
module sfr_map_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0;
  logic       sfr_rd = 1'b0, sfr_wr = 1'b0, phase_s2p2 = 1'b0;
  logic [7:0] sfr_rdata;
  logic       sel_std, sel_map, sel_dir;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sfr_map_ctrl u_dut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .phase_s2p2(phase_s2p2),
    .sfr_rdata(sfr_rdata), .sel_std(sel_std), .sel_map(sel_map),
    .sel_dir(sel_dir)
  );

  // Scoreboard queues
  logic [2:0] q_sel[$];
  logic [7:0] q_rd[$];
  string      q_tag[$];

  // Reference model state, from the requirements
  logic [1:0] m_hi = 2'b10, m_lo = 2'b01;
  logic       m_map = 1'b0, m_dir = 1'b0;
  logic [5:0] m_ip = '0;
  int         m_cnt = 0;

  function automatic bit is_port(input logic [7:0] a);
    return a == 8'h80 || a == 8'h90 || a == 8'hA0 || a == 8'hB0 ||
           a == 8'hE8 || a == 8'hF8;
  endfunction

  // sel encoding {dir, map, std}
  task automatic drive(input logic [7:0] a, input bit r, input bit w,
                       input logic [7:0] d, input bit ph, input string tag);
    logic [2:0] es;
    logic [7:0] er;
    @(negedge clk);
    sfr_addr = a; sfr_rd = r; sfr_wr = w; sfr_wdata = d; phase_s2p2 = ph;
    if (!(r || w))                   es = 3'b000;
    else if (a == 8'hB1 || a == 8'hB9) es = 3'b001;
    else if (is_port(a) && m_dir)    es = 3'b100;
    else if (a >= 8'hC1 && a <= 8'hCB && m_map) es = 3'b010;
    else                             es = 3'b001;
    if (r && a == 8'hB1)      er = {m_hi, 1'b1, m_map, 2'b00, m_lo};
    else if (r && a == 8'hB9) er = {m_dir, 1'b0, m_ip};
    else                      er = 8'h00;
    q_sel.push_back(es); q_rd.push_back(er); q_tag.push_back(tag);
    if (w && a == 8'hB1) begin
      m_hi = d[7:6]; m_map = d[4]; m_lo = d[1:0];
    end
    if (w && a == 8'hB9) begin
      m_dir = d[7]; m_ip = d[5:0]; m_cnt = 0;
    end else if (m_dir && ph) begin
      m_cnt++;
      if (m_cnt == 2) begin m_dir = 1'b0; m_cnt = 0; end
    end
  endtask

  task automatic idle(input bit ph, input string tag);
    drive(8'h00, 0, 0, 8'h00, ph, tag);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (q_sel.size() > 0) begin
      logic [2:0] es, got;
      logic [7:0] er;
      string tag;
      es = q_sel.pop_front(); er = q_rd.pop_front(); tag = q_tag.pop_front();
      got = {sel_dir, sel_map, sel_std};
      total++;
      if (got !== es || sfr_rdata !== er) begin
        bad++;
        $display("FAIL %s: sel=%b rdata=%h expected sel=%b rdata=%h",
                 tag, got, sfr_rdata, es, er);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    idle(0, "R1 idle after reset");
    drive(8'hB1, 1, 0, 0, 0, "R1 syscon reset value");
    drive(8'hB9, 1, 0, 0, 0, "R1 dirctl reset value");
    idle(0, "R2 no access no select");
    // R3/R4/R5 with both bits clear
    drive(8'hC1, 1, 0, 0, 0, "R3 window low, map off");
    drive(8'hCB, 0, 1, 8'h55, 0, "R3 window high, map off");
    drive(8'h85, 1, 0, 0, 0, "R4 plain address");
    drive(8'h90, 1, 0, 0, 0, "R5 port, dir off");
    // map on
    drive(8'hB1, 0, 1, 8'hFF, 0, "R2 write syscon");
    drive(8'hB1, 1, 0, 0, 0, "R9 syscon readback");
    drive(8'hC1, 1, 0, 0, 0, "R3 window low, map on");
    drive(8'hCB, 0, 1, 8'h12, 0, "R3 window high, map on");
    drive(8'hC0, 1, 0, 0, 0, "R4 below window");
    drive(8'hCC, 1, 0, 0, 0, "R4 above window");
    drive(8'hB1, 1, 0, 0, 0, "R8 syscon stays ordinary");
    idle(1, "R3 map bit sticky over pulse");
    drive(8'hC5, 1, 0, 0, 0, "R3 map still on");
    // direction one-shot
    drive(8'hB9, 0, 1, 8'hC0, 0, "R5 set dir bit");
    drive(8'hB9, 1, 0, 0, 0, "R9 dirctl readback bit6 zero");
    drive(8'hA0, 1, 0, 0, 0, "R5 port to direction area");
    drive(8'hC5, 0, 1, 8'h01, 0, "R3 window unaffected by dir bit");
    drive(8'hB9, 1, 1, 8'h80, 0, "R8 dirctl stays ordinary");
    idle(1, "R6 first pulse");
    drive(8'hF8, 1, 0, 0, 0, "R6 still set after one pulse");
    idle(1, "R6 second pulse");
    drive(8'hF8, 1, 0, 0, 0, "R6 cleared after two pulses");
    drive(8'hB9, 1, 0, 0, 0, "R6 readback cleared");
    // pulse in the set-write cycle does not count
    drive(8'hB9, 0, 1, 8'h80, 1, "R6 set with coincident pulse");
    idle(1, "R6 first counted pulse");
    drive(8'h80, 0, 1, 8'h00, 0, "R6 still set");
    // R7: write on clearing pulse
    drive(8'hB9, 0, 1, 8'h80, 1, "R7 rewrite on clearing pulse");
    drive(8'hB0, 1, 0, 0, 0, "R7 kept set");
    idle(1, "R7 restarted count pulse one");
    drive(8'hB0, 1, 0, 0, 0, "R7 set after one pulse");
    idle(1, "R7 pulse two");
    drive(8'hB0, 1, 0, 0, 0, "R7 cleared after restart");
    drive(8'hB9, 0, 1, 8'h80, 0, "R7 set again");
    idle(1, "R7 pulse one");
    drive(8'hB9, 0, 1, 8'h3F, 1, "R7 clear write on clearing pulse");
    drive(8'hE8, 1, 0, 0, 0, "R7 written zero kept");
    drive(8'hB9, 1, 0, 0, 0, "R9 low bits kept");
    // map off again
    drive(8'hB1, 0, 1, 8'h00, 0, "R3 clear map bit");
    drive(8'hB1, 1, 0, 0, 0, "R9 bit5 reads one");
    drive(8'hC5, 1, 0, 0, 0, "R3 window back to ordinary");
    drive(8'h85, 0, 0, 0, 0, "R10 no read gives zero data");
    idle(0, "R2 trailing idle");
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule